// File: doc/BRIEF.md
# Pipelined Trie Prefix Lookup

This block finds the longest matching IPv4 prefix for a 32-bit destination address. It walks a binary trie that software has already laid out across seven external node memories, one memory per pipeline stage. The first memory is indexed directly by the top 19 address bits, which is a prefix-expanded root level. The next five memories each advance the walk by one address bit. The seventh memory resolves the last 8 bits with one expanded read.

Each memory has a synchronous read port: a 19-bit address and enable are issued in one cycle, and the 32-bit node word returns in the next. A node word holds a prefix-valid flag, a two-bit child-presence code, an 18-bit child pointer and an 11-bit result index. The pipeline accepts one lookup per clock. It returns the index of the deepest prefix node visited, in the order the lookups were accepted, after a fixed latency. A lookup whose walk has already ended still travels through the later stages, but those stages issue no reads for it.

Top module: `trie_lpm_pipe`

## Requirements
- R1: A node word is decoded as bit 31 prefix-valid, bits 30:29 child-presence code, bits 28:11 child pointer and bits 10:0 result index.
- R2: Stage 1 reads memory 0 at address bits 31:13 of the lookup address. The read is enabled only in a cycle where a lookup is accepted.
- R3: Stages 2 to 6 read memories 1 to 5 at {child pointer, b}. Here b is address bit 12 for memory 1, bit 11 for memory 2, and so on down to bit 8 for memory 5.
- R4: In the child-presence code, bit 0 means a right child exists and bit 1 means a left child exists. An address bit of 1 follows the right child and an address bit of 0 follows the left child.
- R5: If the child the walk needs is absent, the walk ends. No later memory is read for that lookup, and the held index becomes the result.
- R6: A visited node with prefix-valid 1 replaces the held index with its result index, and a node with prefix-valid 0 leaves it unchanged. The held index starts at DEF_IDX, which defaults to 0.
- R7: A memory-0 node with child code 00 supplies its result index as the result even when its prefix-valid bit is 0.
- R8: A memory-5 node with any child present continues the walk to memory 6 at {child pointer bits 10:0, address bits 7:0}. A memory-5 node with code 00 ends the walk.
- R9: One lookup can be accepted every clock. Its result ready strobe appears exactly 8 rising edges after the edge that accepted it, counting that edge, and results leave in acceptance order.
- R10: While the enable input is low, the lookup strobe is ignored and the dropped lookup never produces a ready strobe. Idle cycles produce no ready strobe.
- R11: Reset clears every lookup in flight, so none of them produces a ready strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable; low blocks acceptance of new lookups |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_addr_i | input | 32 | Destination address to match |
| mem_rd_en_o | output | 7 | Read enable per node memory, bit k for memory k |
| mem_rd_addr_o | output | 133 | Read address per memory, memory k in bits 19k+18:19k |
| mem_rdata_i | input | 224 | Node word per memory, returned one cycle after the read, memory k in bits 32k+31:32k |
| res_ready_o | output | 1 | Result strobe |
| res_index_o | output | 11 | Matched result index |

## Verification
A fixed trie is placed in modelled memories. A vector list is then driven through it three ways: back to back, with an idle cycle between lookups, and with the enable toggling every cycle. The first exposes any alignment error between the stage contexts and the returned node words. The second separates real results from bubbles. The third shows that a dropped lookup leaves no trace. The vectors end their walks at every depth. They exercise each child code against both values of the steering bit, nodes with the prefix flag clear beneath ones with it set, a root leaf with the flag clear, and the pointer truncation into the last memory. A trap word sits in the last memory where a walk that failed to stop at memory 5 would land. Directed cases cover the state after reset and a reset that lands while a lookup is in flight.

// File: rtl/trie_pkg.sv
package trie_pkg;
    localparam int IP_W       = 32;
    localparam int ROOT_BITS  = 19;
    localparam int BIT_STAGES = 5;
    localparam int TAIL_BITS  = IP_W - ROOT_BITS - BIT_STAGES;
    localparam int MEM_AW     = ROOT_BITS;
    localparam int NODE_W     = 32;
    localparam int IDX_W      = 11;
    localparam int PTR_W      = MEM_AW - 1;
    localparam int TAIL_PTR   = MEM_AW - TAIL_BITS;
    localparam int NSTAGE     = BIT_STAGES + 2;
    localparam int KID_R      = 0;
    localparam int KID_L      = 1;

    typedef struct packed {
        logic             pfx;
        logic [1:0]       kids;
        logic [PTR_W-1:0] ptr;
        logic [IDX_W-1:0] idx;
    } node_t;

    typedef struct packed {
        logic             vld;
        logic             done;
        logic [IP_W-1:0]  ip;
        logic [IDX_W-1:0] best;
    } ctx_t;
endpackage

// File: rtl/trie_walk_step.sv
module trie_walk_step
    import trie_pkg::*;
#(
    parameter int STAGE = 1
) (
    input  node_t             node_i,
    input  ctx_t              cur_i,
    output ctx_t              nxt_o,
    output logic              rd_en_o,
    output logic [MEM_AW-1:0] rd_addr_o
);
    localparam bit IS_ROOT = (STAGE == 1);

    logic              live;
    logic              take;
    logic              go;
    logic [MEM_AW-1:0] addr;

    assign live = cur_i.vld & ~cur_i.done;
    // Root level is prefix-expanded: a leaf there always carries the answer.
    assign take = node_i.pfx | (IS_ROOT && (node_i.kids == 2'b00));

    generate
        if (STAGE <= BIT_STAGES) begin : g_bit
            localparam int BP = IP_W - ROOT_BITS - STAGE;
            logic dir;
            assign dir  = cur_i.ip[BP];
            assign go   = dir ? node_i.kids[KID_R] : node_i.kids[KID_L];
            assign addr = {node_i.ptr, dir};
        end else begin : g_wide
            logic ptr_hi_unused;
            assign ptr_hi_unused = ^node_i.ptr[PTR_W-1:TAIL_PTR];
            assign go   = |node_i.kids;
            assign addr = {node_i.ptr[TAIL_PTR-1:0], cur_i.ip[TAIL_BITS-1:0]};
        end
    endgenerate

    always_comb begin
        nxt_o = cur_i;
        if (live) begin
            if (take) begin
                nxt_o.best = node_i.idx;
            end
            nxt_o.done = ~go;
        end
    end

    assign rd_en_o   = live & go;
    assign rd_addr_o = (live & go) ? addr : '0;
endmodule

// File: rtl/trie_tail_step.sv
module trie_tail_step
    import trie_pkg::*;
(
    input  node_t             node_i,
    input  ctx_t              cur_i,
    output logic              rdy_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic tail_unused;
    assign tail_unused = ^{node_i.kids, node_i.ptr, cur_i.ip};

    assign rdy_o = cur_i.vld;
    assign idx_o = (cur_i.vld & ~cur_i.done & node_i.pfx) ? node_i.idx : cur_i.best;
endmodule

// File: rtl/trie_lpm_pipe.sv
module trie_lpm_pipe
    import trie_pkg::*;
#(
    parameter logic [IDX_W-1:0] DEF_IDX = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic                     lk_valid_i,
    input  logic [IP_W-1:0]          lk_addr_i,
    output logic [NSTAGE-1:0]        mem_rd_en_o,
    output logic [NSTAGE*MEM_AW-1:0] mem_rd_addr_o,
    input  logic [NSTAGE*NODE_W-1:0] mem_rdata_i,
    output logic                     res_ready_o,
    output logic [IDX_W-1:0]         res_index_o
);
    typedef struct packed {
        ctx_t [NSTAGE-1:0] ctx;
        logic              rdy;
        logic [IDX_W-1:0]  idx;
    } pipe_t;

    pipe_t             st_d, st_q;
    node_t             node      [NSTAGE];
    ctx_t              step_nxt  [NSTAGE-1];
    logic [NSTAGE-1:1] step_en;
    logic [MEM_AW-1:0] step_addr [NSTAGE-1:1];
    logic              tail_rdy;
    logic [IDX_W-1:0]  tail_idx;
    logic              accept;

    assign accept = en_i & lk_valid_i;

    genvar g;
    generate
        for (g = 0; g < NSTAGE; g++) begin : g_node
            assign node[g] = node_t'(mem_rdata_i[g*NODE_W +: NODE_W]);
        end
        for (g = 0; g < NSTAGE - 1; g++) begin : g_step
            trie_walk_step #(.STAGE(g + 1)) u_step (
                .node_i    (node[g]),
                .cur_i     (st_q.ctx[g]),
                .nxt_o     (step_nxt[g]),
                .rd_en_o   (step_en[g+1]),
                .rd_addr_o (step_addr[g+1])
            );
        end
    endgenerate

    trie_tail_step u_tail (
        .node_i (node[NSTAGE-1]),
        .cur_i  (st_q.ctx[NSTAGE-1]),
        .rdy_o  (tail_rdy),
        .idx_o  (tail_idx)
    );

    always_comb begin
        mem_rd_en_o = {step_en, accept};
        mem_rd_addr_o[0 +: MEM_AW] = lk_addr_i[IP_W-1 -: MEM_AW];
        for (int k = 1; k < NSTAGE; k++) begin
            mem_rd_addr_o[k*MEM_AW +: MEM_AW] = step_addr[k];
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.ctx[0].vld  = accept;
        st_d.ctx[0].done = 1'b0;
        st_d.ctx[0].ip   = lk_addr_i;
        st_d.ctx[0].best = DEF_IDX;
        for (int k = 1; k < NSTAGE; k++) begin
            st_d.ctx[k] = step_nxt[k-1];
        end
        st_d.rdy = tail_rdy;
        st_d.idx = tail_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_ready_o = st_q.rdy;
    assign res_index_o = st_q.idx;

    // R10: a lookup offered while disabled never enters the pipe
    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !st_q.ctx[0].vld);

    // R9: the last context reaches the result register one edge later
    p_ready_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctx[NSTAGE-1].vld |=> res_ready_o);

    p_no_bubble_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctx[NSTAGE-1].vld |=> !res_ready_o);

    generate
        for (g = 0; g < NSTAGE - 1; g++) begin : g_chk
            // R5: an ended walk stays ended in every later stage
            p_done_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.ctx[g].vld && st_q.ctx[g].done |=> st_q.ctx[g+1].done);
            // R6: an ended walk keeps its held index unchanged
            p_best_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.ctx[g].vld && st_q.ctx[g].done
                |=> st_q.ctx[g+1].best == $past(st_q.ctx[g].best));
            // R3: a read into memory g+1 lines up with a live context there
            p_read_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
                mem_rd_en_o[g+1] |=> st_q.ctx[g+1].vld && !st_q.ctx[g+1].done);
        end
    endgenerate
endmodule

// File: tb/sim_trie_lpm_pipe.sv
`timescale 1ns/1ps
module sim_trie_lpm_pipe;
    import trie_pkg::*;

    localparam int NV  = 14;
    localparam int LAT = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     en = 1'b1;
    logic                     valid = 1'b0;
    logic [IP_W-1:0]          addr = '0;
    logic [NSTAGE-1:0]        rd_en;
    logic [NSTAGE*MEM_AW-1:0] rd_addr;
    logic [NSTAGE*NODE_W-1:0] rdata = '0;
    logic                     res_ready;
    logic [IDX_W-1:0]         res_index;

    int checks = 0;
    int fails  = 0;

    trie_lpm_pipe u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en),
        .lk_valid_i    (valid),
        .lk_addr_i     (addr),
        .mem_rd_en_o   (rd_en),
        .mem_rd_addr_o (rd_addr),
        .mem_rdata_i   (rdata),
        .res_ready_o   (res_ready),
        .res_index_o   (res_index)
    );

    always #2.5 clk = ~clk;

    // Node memories: sparse model, absent words read as zero
    bit [31:0] mem [int unsigned];

    function automatic bit [31:0] rd(int k, logic [18:0] a);
        int unsigned key = k * (1 << 19) + int'(a);
        return mem.exists(key) ? mem[key] : 32'h0;
    endfunction

    function automatic void put(int k, logic [18:0] a, bit [31:0] w);
        mem[k * (1 << 19) + int'(a)] = w;
    endfunction

    // R1 layout: prefix flag, child code (bit0 right, bit1 left), pointer, index
    function automatic bit [31:0] nd(bit p, bit [1:0] lr, bit [17:0] ptr, bit [10:0] idx);
        return {p, lr, ptr, idx};
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < NSTAGE; k++) begin
            if (rd_en[k]) rdata[k*NODE_W +: NODE_W] <= rd(k, rd_addr[k*MEM_AW +: MEM_AW]);
        end
    end

    // {address[31:0], expected index[10:0]}; address = {root19, bits 12..8, low8}
    localparam logic [42:0] VEC [NV] = '{
        {19'h00001, 5'b10101, 8'h12, 11'd5},
        {19'h00002, 5'b00000, 8'h00, 11'd7},
        {19'h00002, 5'b01111, 8'hFF, 11'd7},
        {19'h00002, 5'b10000, 8'h00, 11'd9},
        {19'h00002, 5'b11100, 8'h00, 11'd9},
        {19'h00002, 5'b11010, 8'h00, 11'd12},
        {19'h00002, 5'b11000, 8'h00, 11'd12},
        {19'h00002, 5'b11001, 8'hAB, 11'd20},
        {19'h00002, 5'b11001, 8'hAC, 11'd14},
        {19'h00003, 5'b10000, 8'h00, 11'd0},
        {19'h00003, 5'b00000, 8'h00, 11'd3},
        {19'h7FFFF, 5'b11111, 8'hFF, 11'd30},
        {19'h7FFFF, 5'b00000, 8'h00, 11'd0},
        {19'h12345, 5'b11111, 8'hFF, 11'd0}
    };
    string vtag [NV] = '{"R7", "R4 R1", "R3", "R3 R6", "R4 R5", "R3 R5", "R4 R5",
                         "R8 R1", "R8 R6", "R6 R4", "R4 R2", "R8 R5", "R5", "R2 R7"};

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_trie();
        put(0, 19'h00001, nd(0, 2'b00, 18'h0, 11'd5));
        put(0, 19'h00002, nd(1, 2'b01, 18'h10, 11'd7));
        put(0, 19'h00003, nd(0, 2'b10, 18'h40, 11'd0));
        put(0, 19'h7FFFF, nd(0, 2'b11, 18'h50, 11'd0));
        put(1, {18'h10, 1'b1}, nd(1, 2'b11, 18'h20, 11'd9));
        put(1, {18'h40, 1'b0}, nd(1, 2'b00, 18'h0, 11'd3));
        put(1, {18'h50, 1'b1}, nd(0, 2'b01, 18'h51, 11'd0));
        put(2, {18'h20, 1'b0}, nd(0, 2'b00, 18'h0, 11'd99));
        put(2, {18'h20, 1'b1}, nd(0, 2'b10, 18'h30, 11'd0));
        put(2, {18'h51, 1'b1}, nd(0, 2'b01, 18'h52, 11'd0));
        put(3, {18'h30, 1'b0}, nd(1, 2'b10, 18'h31, 11'd12));
        put(3, {18'h52, 1'b1}, nd(0, 2'b01, 18'h53, 11'd0));
        put(4, {18'h31, 1'b0}, nd(0, 2'b01, 18'h32, 11'd0));
        put(4, {18'h53, 1'b1}, nd(1, 2'b01, 18'h54, 11'd30));
        put(5, {18'h32, 1'b1}, nd(1, 2'b11, 18'h3F805, 11'd14));
        put(5, {18'h54, 1'b1}, nd(0, 2'b00, 18'h0, 11'd0));
        put(6, {11'h005, 8'hAB}, nd(1, 2'b00, 18'h0, 11'd20));
        put(6, {11'h000, 8'hFF}, nd(1, 2'b00, 18'h0, 11'd77)); // trap: reached only if R8 stop fails
    endtask

    // mode 0: back to back; 1: idle cycle between lookups; 2: enable low on odd cycles
    task automatic run_stream(int mode);
        int acc_i[$];
        int acc_t[$];
        int sent = 0;
        for (int t = 0; t < 2 * NV + LAT + 4; t++) begin
            @(negedge clk);
            if (res_ready) begin
                if (acc_i.size() == 0) begin
                    chk(1'b0, "R10", "ready without accepted lookup", 1, 0);
                end else begin
                    int vi = acc_i.pop_front();
                    int ti = acc_t.pop_front();
                    chk(res_index == VEC[vi][10:0], vtag[vi], "result index",
                        int'(res_index), int'(VEC[vi][10:0]));
                    chk(t == ti + LAT, "R9", "result cycle", t, ti + LAT);
                end
            end
            en    = (mode != 2) || (t % 2 == 0);
            valid = (sent < NV) && ((mode != 1) || (t % 2 == 0));
            addr  = (sent < NV) ? VEC[sent][42:11] : '0;
            if (valid) begin
                if (en) begin
                    acc_i.push_back(sent);
                    acc_t.push_back(t);
                end
                sent++;
            end
        end
        en = 1'b1;
        valid = 1'b0;
        chk(acc_i.size() == 0, "R9", "lookups left undelivered", acc_i.size(), 0);
    endtask

    task automatic count_ready(int cycles, output int n);
        n = 0;
        for (int t = 0; t < cycles; t++) begin
            @(negedge clk);
            if (res_ready) n++;
        end
    endtask

    initial begin
        int n;
        load_trie();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_ready == 1'b0, "R11", "ready after reset", int'(res_ready), 0);

        run_stream(0);
        run_stream(1);
        run_stream(2);

        // R10: lookups offered with enable low are dropped
        en = 1'b0;
        valid = 1'b1;
        addr = VEC[1][42:11];
        repeat (4) @(negedge clk);
        en = 1'b1;
        valid = 1'b0;
        count_ready(LAT + 4, n);
        chk(n == 0, "R10", "ready count after disabled offers", n, 0);

        // R11: reset while a lookup is in flight
        valid = 1'b1;
        addr = VEC[7][42:11];
        @(negedge clk);
        valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        count_ready(LAT + 4, n);
        chk(n == 0, "R11", "ready count after reset in flight", n, 0);

        // R9: pipe still works after the reset
        valid = 1'b1;
        addr = VEC[11][42:11];
        @(negedge clk);
        valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        chk(res_ready == 1'b1, "R9", "ready after reset recovery", int'(res_ready), 1);
        chk(res_index == 11'd30, "R5", "index after reset recovery", int'(res_index), 30);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule